// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Image Signature Check

This block talks to a three-wire serial configuration EEPROM. It drives the chip select, the shift clock and the serial data into the device, and samples the serial data coming back. Every transfer is a read. The block can fetch one word at a caller-chosen address. It can also run an automatic load pass over the whole image.

The load pass works in three steps. First it sends a probe read of word 0 with a 6-bit address, and from the reply it decides whether the device uses 6 or 8 address bits. Next it reads words 0 to 63 with that width and adds them with a 16-bit wrapping sum. The first three words are kept as a 48-bit station address. Last, the sum is compared with the fixed signature 0xBABA. On a match the address is published and a valid flag is set. On a mismatch the published address is forced to zero and the flag is cleared.

Each half of a shift-clock period lasts `HALF_CYC` system clocks. This parameter is chosen so that every clock phase lasts at least one microsecond.

Top module: `sprom_loader`

## Requirements
- R1: While reset is low, and right after it is released, `ee_cs_o`, `ee_sk_o`, `ee_di_o`, `busy_o`, `done_o`, `sum_ok_o` and `wide_o` are 0, and `station_o` is all zero.
- R2: A read frame starts with one half-period with chip select low. Chip select is then raised, and the bits 1, 1, 0 are sent, followed by the address MSB first. Each bit is put on `ee_di_o` while `ee_sk_o` is low and is held through the high phase that follows. Every shift-clock phase, low or high, lasts exactly `HALF_CYC` clocks. Chip select first rises `HALF_CYC` clocks after `busy_o` rises.
- R3: After the command, one low half-period follows. Then 16 data bits are taken MSB first, each sampled at the end of a high phase. A single read (`auto_i`=0) returns the word on `word_o`. It uses the address width in effect: 6 bits (the low bits of `addr_i`) after reset, or the width found by the last load pass.
- R4: Chip select falls after the low phase of the 16th data bit. In the first cycle with chip select low, `busy_o` falls and `done_o` is high. `done_o` is high for exactly one cycle.
- R5: A load pass (`auto_i`=1) first reads word 0 with a 6-bit address. If the result is 0xFFFF, `wide_o` becomes 1 (8-bit addresses). Otherwise `wide_o` becomes 0 (6-bit addresses).
- R6: After the probe, the load pass reads words 0 to 63 in increasing order with the detected width, which makes 65 chip-select frames in all. `word_o` then holds word 63.
- R7: When the 16-bit wrapping sum of words 0 to 63 equals 0xBABA, `sum_ok_o` is set at the end of the pass and `station_o` = {word2, word1, word0}. Address byte k is at bits 8k+7:8k: byte 0 is bits 7:0 of word 0 and byte 1 is bits 15:8 of word 0.
- R8: When the sum differs from 0xBABA, `sum_ok_o` is 0 and `station_o` is zero after the pass.
- R9: A `start_i` pulse while `busy_o` is high is ignored: it adds no frame, no extra `done_o` pulse and no change to the result.
- R10: A `start_i` pulse sampled in the cycle where `done_o` is high is accepted, so `busy_o` is high in the next cycle.
- R11: A single read leaves `station_o`, `sum_ok_o` and `wide_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, one cycle |
| auto_i | input | 1 | 1 = load pass, 0 = single read (sampled with start) |
| addr_i | input | AW_WIDE | Word address for a single read |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| word_o | output | 16 | Last word read |
| station_o | output | 48 | Captured station address |
| sum_ok_o | output | 1 | Image signature matched |
| wide_o | output | 1 | 1 = 8-bit addresses detected |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM shift clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |

## Verification
The completion of one transaction and the start of the next can fall in the same cycle. A new start strobe is raised in the very cycle that `done_o` is seen high. The bench expects `busy_o` one cycle later, and then a second completion that returns the newly addressed word. A second contention is a start strobe that arrives in the middle of a load pass. It is judged by counting chip-select frames and completion pulses, which must be exactly 65 and exactly one.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

  localparam int WORD_W = 16;
  localparam logic [2:0] RD_OPCODE = 3'b110;
  localparam logic [WORD_W-1:0] BLANK_WORD = 16'hFFFF;

  typedef enum logic [2:0] {
    EN_IDLE,
    EN_LEAD,
    EN_CMD,
    EN_TURN,
    EN_DATA
  } eng_state_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ONE,
    SQ_PROBE,
    SQ_LOAD
  } seq_state_t;

endpackage

// File: rtl/sprom_shift_engine.sv
module sprom_shift_engine
  import sprom_pkg::*;
#(
  parameter int HALF_CYC  = 50,
  parameter int AW_NARROW = 6,
  parameter int AW_WIDE   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  input  logic               wide_i,
  input  logic [AW_WIDE-1:0] addr_i,
  input  logic               sdo_i,
  output logic               cs_o,
  output logic               sk_o,
  output logic               di_o,
  output logic [WORD_W-1:0]  word_o,
  output logic               xfer_end_o
);

  localparam int CW  = 3 + AW_WIDE;
  localparam int TW  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int MXB = (CW > WORD_W) ? CW : WORD_W;
  localparam int BW  = $clog2(MXB + 1);

  eng_state_t          state;
  logic [TW-1:0]       tick;
  logic                half;
  logic [CW-1:0]       cmd_sr;
  logic [BW-1:0]       bits;
  logic [WORD_W-1:0]   shreg;
  logic                tick_end;

  function automatic logic [CW-1:0] build_cmd(input logic wide,
                                              input logic [AW_WIDE-1:0] a);
    logic [CW-1:0] c;
    if (wide) c = {RD_OPCODE, a};
    else      c = CW'({RD_OPCODE, a[AW_NARROW-1:0]}) << (AW_WIDE - AW_NARROW);
    return c;
  endfunction

  function automatic logic [BW-1:0] cmd_len(input logic wide);
    return wide ? BW'(CW) : BW'(3 + AW_NARROW);
  endfunction

  assign tick_end = (tick == TW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= EN_IDLE;
      tick   <= '0;
      half   <= 1'b0;
      cmd_sr <= '0;
      bits   <= '0;
      shreg  <= '0;
    end else if (state == EN_IDLE) begin
      tick <= '0;
      half <= 1'b0;
      if (go_i) begin
        state  <= EN_LEAD;
        cmd_sr <= build_cmd(wide_i, addr_i);
        bits   <= cmd_len(wide_i);
      end
    end else begin
      tick <= tick_end ? '0 : tick + 1'b1;
      if (tick_end) begin
        case (state)
          EN_LEAD: begin
            state <= EN_CMD;
            half  <= 1'b0;
          end
          EN_CMD: begin
            if (!half) begin
              half <= 1'b1;
            end else begin
              half   <= 1'b0;
              cmd_sr <= cmd_sr << 1;
              bits   <= bits - 1'b1;
              if (bits == BW'(1)) state <= EN_TURN;
            end
          end
          EN_TURN: begin
            state <= EN_DATA;
            half  <= 1'b1;
            bits  <= BW'(WORD_W);
          end
          EN_DATA: begin
            if (half) begin
              shreg <= {shreg[WORD_W-2:0], sdo_i};
              half  <= 1'b0;
            end else begin
              half <= 1'b1;
              bits <= bits - 1'b1;
              if (bits == BW'(1)) state <= EN_IDLE;
            end
          end
          default: state <= EN_IDLE;
        endcase
      end
    end
  end

  assign cs_o       = (state == EN_CMD) || (state == EN_TURN) || (state == EN_DATA);
  assign sk_o       = ((state == EN_CMD) || (state == EN_DATA)) && half;
  assign di_o       = (state == EN_CMD) && cmd_sr[CW-1];
  assign word_o     = shreg;
  assign xfer_end_o = (state == EN_DATA) && tick_end && !half && (bits == BW'(1));

  // R2
  di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_o && $past(sk_o)) |-> $stable(di_o));

  // R2
  phase_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sk_o) |-> $past(tick_end));

  // R2
  sk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sk_o |-> cs_o);

  // R4
  frame_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end_o |=> !cs_o);

  // R9
  go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (state == EN_IDLE));

endmodule

// File: rtl/sprom_sequencer.sv
module sprom_sequencer
  import sprom_pkg::*;
#(
  parameter int AW_WIDE = 8,
  parameter int NWORDS  = 64,
  localparam int IW     = $clog2(NWORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               auto_i,
  input  logic [AW_WIDE-1:0] addr_i,
  input  logic               xfer_end_i,
  input  logic [WORD_W-1:0]  eng_word_i,
  output logic               eng_go_o,
  output logic               eng_wide_o,
  output logic [AW_WIDE-1:0] eng_addr_o,
  output logic               clear_o,
  output logic               word_valid_o,
  output logic               last_o,
  output logic [IW-1:0]      word_idx_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               wide_o,
  output logic [WORD_W-1:0]  word_o
);

  seq_state_t        state;
  logic [IW-1:0]     idx;
  logic              issue_q;
  logic              wide_q;
  logic              busy_q;
  logic              done_q;
  logic [WORD_W-1:0] word_q;
  logic              accept;
  logic              at_last;

  assign accept  = (state == SQ_IDLE) && start_i;
  assign at_last = (idx == IW'(NWORDS - 1));

  always_comb begin
    eng_go_o   = 1'b0;
    eng_wide_o = wide_q;
    eng_addr_o = '0;
    if (accept) begin
      eng_go_o   = 1'b1;
      eng_wide_o = auto_i ? 1'b0 : wide_q;
      eng_addr_o = auto_i ? '0 : addr_i;
    end else if ((state == SQ_LOAD) && issue_q) begin
      eng_go_o   = 1'b1;
      eng_addr_o = AW_WIDE'(idx);
    end
  end

  assign clear_o      = accept && auto_i;
  assign word_valid_o = (state == SQ_LOAD) && xfer_end_i;
  assign last_o       = word_valid_o && at_last;
  assign word_idx_o   = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      idx     <= '0;
      issue_q <= 1'b0;
      wide_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (eng_go_o) issue_q <= 1'b0;
      if (xfer_end_i) word_q <= eng_word_i;
      case (state)
        SQ_IDLE: begin
          if (start_i) begin
            busy_q <= 1'b1;
            state  <= auto_i ? SQ_PROBE : SQ_ONE;
          end
        end
        SQ_ONE: begin
          if (xfer_end_i) begin
            state  <= SQ_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
        SQ_PROBE: begin
          if (xfer_end_i) begin
            wide_q  <= (eng_word_i == BLANK_WORD);
            idx     <= '0;
            issue_q <= 1'b1;
            state   <= SQ_LOAD;
          end
        end
        SQ_LOAD: begin
          if (xfer_end_i) begin
            if (at_last) begin
              state  <= SQ_IDLE;
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              idx     <= idx + 1'b1;
              issue_q <= 1'b1;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign wide_o = wide_q;
  assign word_o = word_q;

  // R4
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9
  single_one_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_ONE) |-> !eng_go_o);

  // R6
  load_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && !at_last) |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/sprom_image_check.sv
module sprom_image_check
  import sprom_pkg::*;
#(
  parameter int NWORDS            = 64,
  parameter logic [15:0] SIGNATURE = 16'hBABA,
  localparam int IW               = $clog2(NWORDS),
  localparam int SW               = 3 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              word_valid_i,
  input  logic              finish_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sum_ok_o,
  output logic [SW-1:0]     station_o
);

  logic [WORD_W-1:0] sum_q, sum_next;
  logic [SW-1:0]     raw_q, raw_next;
  logic              sig_match;

  function automatic logic [WORD_W-1:0] add_word(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [SW-1:0] place_word(input logic [SW-1:0] r,
                                               input logic [IW-1:0] i,
                                               input logic [WORD_W-1:0] w);
    logic [SW-1:0] o;
    o = r;
    for (int k = 0; k < 3; k++) begin
      if (int'(i) == k) o[k*WORD_W +: WORD_W] = w;
    end
    return o;
  endfunction

  assign sum_next  = add_word(sum_q, word_i);
  assign raw_next  = place_word(raw_q, idx_i, word_i);
  assign sig_match = (sum_next == SIGNATURE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q     <= '0;
      raw_q     <= '0;
      sum_ok_o  <= 1'b0;
      station_o <= '0;
    end else if (clear_i) begin
      sum_q <= '0;
      raw_q <= '0;
    end else if (word_valid_i) begin
      sum_q <= sum_next;
      raw_q <= raw_next;
      if (finish_i) begin
        sum_ok_o  <= sig_match;
        station_o <= sig_match ? raw_next : '0;
      end
    end
  end

  // R8
  zero_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_ok_o |-> (station_o == '0));

  // R7
  ok_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_ok_o) |-> $past(finish_i));

endmodule

// File: rtl/sprom_loader.sv
module sprom_loader
  import sprom_pkg::*;
#(
  parameter int HALF_CYC          = 50,
  parameter int AW_NARROW         = 6,
  parameter int AW_WIDE           = 8,
  parameter int NWORDS            = 64,
  parameter logic [15:0] SIGNATURE = 16'hBABA
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               auto_i,
  input  logic [AW_WIDE-1:0] addr_i,
  input  logic               ee_do_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [15:0]        word_o,
  output logic [47:0]        station_o,
  output logic               sum_ok_o,
  output logic               wide_o,
  output logic               ee_cs_o,
  output logic               ee_sk_o,
  output logic               ee_di_o
);

  localparam int IW = $clog2(NWORDS);

  logic               eng_go, eng_wide, xfer_end;
  logic [AW_WIDE-1:0] eng_addr;
  logic [WORD_W-1:0]  eng_word;
  logic               clear, word_valid, last;
  logic [IW-1:0]      word_idx;

  sprom_shift_engine #(
    .HALF_CYC (HALF_CYC),
    .AW_NARROW(AW_NARROW),
    .AW_WIDE  (AW_WIDE)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (eng_go),
    .wide_i    (eng_wide),
    .addr_i    (eng_addr),
    .sdo_i     (ee_do_i),
    .cs_o      (ee_cs_o),
    .sk_o      (ee_sk_o),
    .di_o      (ee_di_o),
    .word_o    (eng_word),
    .xfer_end_o(xfer_end)
  );

  sprom_sequencer #(
    .AW_WIDE(AW_WIDE),
    .NWORDS (NWORDS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .auto_i      (auto_i),
    .addr_i      (addr_i),
    .xfer_end_i  (xfer_end),
    .eng_word_i  (eng_word),
    .eng_go_o    (eng_go),
    .eng_wide_o  (eng_wide),
    .eng_addr_o  (eng_addr),
    .clear_o     (clear),
    .word_valid_o(word_valid),
    .last_o      (last),
    .word_idx_o  (word_idx),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .wide_o      (wide_o),
    .word_o      (word_o)
  );

  sprom_image_check #(
    .NWORDS   (NWORDS),
    .SIGNATURE(SIGNATURE)
  ) u_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear),
    .word_valid_i(word_valid),
    .finish_i    (last),
    .idx_i       (word_idx),
    .word_i      (eng_word),
    .sum_ok_o    (sum_ok_o),
    .station_o   (station_o)
  );

  // R4
  done_frame_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!ee_cs_o && !busy_o));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> busy_o);

endmodule

// File: tb/tb_sprom_loader.sv
module tb_sprom_loader;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        auto_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        busy_o, done_o, sum_ok_o, wide_o;
  logic        ee_cs_o, ee_sk_o, ee_di_o;
  logic [15:0] word_o;
  logic [47:0] station_o;
  logic        m_do = 1'b1;

  sprom_loader #(.HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_i(auto_i),
    .addr_i(addr_i), .ee_do_i(m_do), .busy_o(busy_o), .done_o(done_o),
    .word_o(word_o), .station_o(station_o), .sum_ok_o(sum_ok_o),
    .wide_o(wide_o), .ee_cs_o(ee_cs_o), .ee_sk_o(ee_sk_o), .ee_di_o(ee_di_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // EEPROM model: captures opcode and address on rising shift clock,
  // floats high (pull-up) until its own address is complete.
  logic [15:0] img [256];
  logic        model_wide = 1'b0;
  int          m_cnt = 0;
  int          m_aw, m_k;
  logic [2:0]  m_op = '0;
  logic [7:0]  m_addr = '0;
  int          frames = 0;

  always @(posedge ee_sk_o or negedge ee_cs_o) begin
    if (!ee_cs_o) begin
      m_cnt = 0;
      m_do  = 1'b1;
    end else begin
      m_cnt++;
      m_aw = model_wide ? 8 : 6;
      if (m_cnt == 1) m_addr = '0;
      if (m_cnt <= 3) m_op = {m_op[1:0], ee_di_o};
      else if (m_cnt <= 3 + m_aw) m_addr = {m_addr[6:0], ee_di_o};
      else begin
        m_k  = m_cnt - 4 - m_aw;
        m_do = (m_k < 16) ? img[m_addr][15-m_k] : 1'b1;
      end
    end
  end

  always @(posedge ee_cs_o) frames++;

  // Port monitor, sampled away from the active edge
  int   cyc = 0, run = 0, phase_err = 0, di_err = 0, done_cnt = 0;
  int   t_busy = 0, t_cs = 0;
  logic p_cs = 1'b0, p_sk = 1'b0, p_di = 1'b0, p_busy = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (done_o) done_cnt++;
    if (busy_o && !p_busy) t_busy = cyc;
    if (ee_cs_o && !p_cs) begin
      t_cs = cyc;
      run  = 1;
    end else if (ee_cs_o && p_cs) begin
      if (ee_sk_o != p_sk) begin
        if (run != HALF) phase_err++;
        run = 1;
      end else run++;
      if (ee_sk_o && p_sk && (ee_di_o != p_di)) di_err++;
    end else if (!ee_cs_o && p_cs) begin
      if (run != HALF) phase_err++;
    end
    p_cs = ee_cs_o; p_sk = ee_sk_o; p_di = ee_di_o; p_busy = busy_o;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [47:0] exp_station;

  task automatic fill_image(input bit wide_dev, input bit corrupt);
    logic [15:0] s;
    for (int i = 0; i < 256; i++) img[i] = 16'(i * 16'h0B3D) ^ 16'h5A21;
    img[0] = wide_dev ? 16'hFFFF : 16'h2301;
    img[1] = 16'h6745;
    img[2] = 16'hAB89;
    s = '0;
    for (int i = 0; i < 63; i++) s = s + img[i];
    img[63] = 16'hBABA - s;
    exp_station = {img[2], img[1], img[0]};
    if (corrupt) img[10] = img[10] ^ 16'h0100;
  endtask

  task automatic do_start(input logic auto_mode, input logic [7:0] a);
    @(negedge clk);
    start_i = 1'b1; auto_i = auto_mode; addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done_o && n < 40000);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 cs", ee_cs_o, 0);
    chk("R1 sk", ee_sk_o, 0);
    chk("R1 busy", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 di", ee_di_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 sum_ok", sum_ok_o, 0);
    chk("R1 wide", wide_o, 0);
    chk("R1 station", station_o, 0);
  endtask

  task automatic test_single_narrow();
    int d0;
    model_wide = 1'b0;
    fill_image(1'b0, 1'b0);
    d0 = done_cnt;
    do_start(1'b0, 8'h05);
    wait_done();
    chk("R3 single word", word_o, img[5]);
    chk("R4 cs low at done", ee_cs_o, 0);
    chk("R4 busy low at done", busy_o, 0);
    @(negedge clk);
    chk("R4 done one cycle", done_o, 0);
    chk("R4 one done pulse", done_cnt - d0, 1);
    chk("R2 opcode", m_op, 3'b110);
    chk("R2 address", m_addr, 8'h05);
    chk("R2 lead-in length", t_cs - t_busy, HALF);
    chk("R2 phase lengths", phase_err, 0);
    chk("R2 data held in high", di_err, 0);
  endtask

  task automatic test_auto(input bit wide_dev, input bit corrupt, input string tag);
    int f0;
    model_wide = wide_dev;
    fill_image(wide_dev, corrupt);
    f0 = frames;
    do_start(1'b1, 8'h00);
    wait_done();
    @(negedge clk);
    chk({tag, " R5 width"}, wide_o, wide_dev);
    chk({tag, " R6 frames"}, frames - f0, 65);
    chk({tag, " R6 last addr"}, m_addr, 8'd63);
    chk({tag, " R6 last word"}, word_o, img[63]);
    if (corrupt) begin
      chk({tag, " R8 flag"}, sum_ok_o, 0);
      chk({tag, " R8 station"}, station_o, 0);
    end else begin
      chk({tag, " R7 flag"}, sum_ok_o, 1);
      chk({tag, " R7 station"}, station_o, exp_station);
    end
    chk({tag, " R2 phases"}, phase_err, 0);
  endtask

  task automatic test_single_keeps(input logic [7:0] a);
    logic [47:0] st;
    logic ok, wd;
    st = station_o; ok = sum_ok_o; wd = wide_o;
    do_start(1'b0, a);
    wait_done();
    chk("R3 word at width in effect", word_o, img[a]);
    chk("R3 address sent", m_addr, a);
    @(negedge clk);
    chk("R11 station kept", station_o, st);
    chk("R11 flag kept", sum_ok_o, ok);
    chk("R11 width kept", wide_o, wd);
  endtask

  task automatic test_busy_start();
    int f0, d0;
    f0 = frames; d0 = done_cnt;
    do_start(1'b1, 8'h00);
    repeat (200) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      do_start(1'b0, 8'h03);
      repeat (150) @(negedge clk);
    end
    wait_done();
    @(negedge clk);
    chk("R9 frames", frames - f0, 65);
    chk("R9 done pulses", done_cnt - d0, 1);
    chk("R9 word", word_o, img[63]);
    chk("R9 flag", sum_ok_o, 1);
  endtask

  task automatic test_back_to_back();
    int d0;
    d0 = done_cnt;
    do_start(1'b0, 8'h07);
    wait_done();
    chk("R10 first word", word_o, img[7]);
    start_i = 1'b1; auto_i = 1'b0; addr_i = 8'h08;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10 busy after restart", busy_o, 1);
    wait_done();
    chk("R10 second word", word_o, img[8]);
    @(negedge clk);
    chk("R10 done pulses", done_cnt - d0, 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_single_narrow();
    test_auto(1'b0, 1'b0, "narrow");
    test_single_keeps(8'h09);
    test_auto(1'b0, 1'b1, "bad");
    test_auto(1'b1, 1'b0, "wide");
    test_single_keeps(8'hA5);
    test_busy_start();
    test_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule